// File: doc/BRIEF.md
# Two-Thread Capped Buffer Allocator

This block sits between a micro-op queue and the out-of-order core of a two-thread pipeline. Each cycle it looks at the head micro-op of each thread. For every micro-op it accepts, it hands out a reorder-buffer slot. It also hands out a load-queue slot or a store-queue slot when the micro-op asks for one. The three pools are shared by the two threads. In two-thread operation each thread is held to half of every pool, so one thread cannot starve the other and neither thread can deadlock. When a thread has used up a slot type it needs, it gets its own stall signal, and the other thread keeps being served.

When both threads are eligible, grants alternate between them. A lone eligible thread is served on every cycle. In single-thread operation, chosen by an input, the selected thread may fill each pool completely and the other thread is ignored. Retirement returns slots one per cycle, tagged with a thread and a slot type. The slots of each thread form a circular region, so indices come out in ring order and a release always returns the oldest slot.

Top module: `ualloc_top`

## Requirements
- R1: After reset all slot counts are zero and the pick priority favours thread 0. The first reorder index granted to thread 0 is 0, and the first granted to thread 1 is ROB_DEPTH/2.
- R2: With `mode_single` low, a thread never holds more than ROB_DEPTH/2 reorder slots, LD_DEPTH/2 load slots or ST_DEPTH/2 store slots.
- R3: With `mode_single` high, only thread `single_tid` is served, and it may hold the full depth of each pool. The other thread never receives a take and never receives a stall.
- R4: When both threads can be granted in the same cycle, the thread that was not granted most recently wins. After reset this is thread 0.
- R5: When only one thread can be granted, it is granted in that cycle, on every cycle this holds. At most one micro-op is granted per cycle.
- R6: An enabled thread whose head micro-op is valid is stalled in a cycle when any slot type it needs is at its limit. A stalled thread gets no take in that cycle, and the other thread is still considered.
- R7: A grant is all-or-nothing. A micro-op that needs a load slot (or a store slot) is granted only if both that slot and a reorder slot are free. A stalled micro-op consumes nothing.
- R8: Releases use `rel_kind` as follows: 0 = reorder, 1 = load, 2 = store, 3 = none. A release for the named thread and kind lowers its count at the next clock edge, so the freed slot is usable in the following cycle. A release of a kind whose count is zero is ignored.
- R9: Indices are valid in the same cycle as the take. Each index is the region base plus the thread's ring position. The base is tid × DEPTH/2 in two-thread operation and 0 in single-thread operation. The ring position advances by one per grant and wraps to 0 after the last slot of the region.
- R10: In a cycle where `mode_single` or `single_tid` differs from its value in the previous cycle, nothing is taken and nothing is stalled. At the next edge all counts and ring positions return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_single | input | 1 | 1 = single-thread operation |
| single_tid | input | 1 | Thread served in single-thread operation |
| uop_valid | input | 2 | Head micro-op present, per thread |
| uop_ld | input | 2 | Head micro-op needs a load slot, per thread |
| uop_st | input | 2 | Head micro-op needs a store slot, per thread |
| uop_take | output | 2 | Head micro-op accepted this cycle, per thread |
| thr_stall | output | 2 | Thread blocked by a slot limit, per thread |
| gnt_valid | output | 1 | A micro-op was granted this cycle |
| gnt_tid | output | 1 | Thread of the granted micro-op |
| gnt_rob | output | $clog2(ROB_DEPTH) | Reorder slot index |
| gnt_ld_valid | output | 1 | A load slot was granted |
| gnt_ld | output | $clog2(LD_DEPTH) | Load slot index |
| gnt_st_valid | output | 1 | A store slot was granted |
| gnt_st | output | $clog2(ST_DEPTH) | Store slot index |
| rel_valid | input | 1 | Release present |
| rel_tid | input | 1 | Thread of the release |
| rel_kind | input | 2 | Slot type being released |

## Verification
Takes, stalls and indices are combinational, so they are due in the very cycle the head micro-op is presented. Releases and configuration changes take effect one edge later, in the following cycle. The bench therefore drives each cycle's inputs just after the falling edge. It compares the outputs a short delay later, before the next rising edge. It advances its arithmetic model of counts, ring positions and priority only at that rising edge. This keeps every expected value aligned with the cycle in which the design commits it.

// File: rtl/ualloc_pkg.sv
// Shared definitions for the two-thread capped allocator.
// Assumes exactly two hardware threads.
package ualloc_pkg;
    localparam int NTHR = 2;

    // Slot type carried on the release interface.
    typedef enum logic [1:0] {
        RK_ROB  = 2'd0,
        RK_LD   = 2'd1,
        RK_ST   = 2'd2,
        RK_NONE = 2'd3
    } res_kind_e;
endpackage

// File: rtl/ualloc_ring.sv
// One thread's view of one slot pool: occupancy count plus circular
// write position inside the thread's region. Assumes in-order release
// (oldest slot first) and DEPTH even and at least 2.
module ualloc_ring #(
    parameter int DEPTH = 126,
    parameter int TID   = 0,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          alloc,
    input  logic          rel_i,
    output logic          full,
    output logic [IW-1:0] idx
);
    localparam int HALF = DEPTH / 2;

    logic [CW-1:0] count;
    logic [CW-1:0] tail;
    logic [CW-1:0] limit;
    logic [CW-1:0] base;
    logic          rel_eff;

    // Region size and start for the current operating mode.
    always_comb begin
        limit   = single ? CW'(DEPTH) : CW'(HALF);
        base    = single ? '0 : CW'(TID * HALF);
        full    = (count >= limit);
        rel_eff = rel_i && (count != '0);
        idx     = IW'(base + tail);
    end

    // Occupancy: +1 on grant, -1 on release, cleared on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            case ({alloc, rel_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Ring position: advance per grant, wrap at region end.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tail <= '0;
        end else if (alloc) begin
            tail <= (tail == limit - 1'b1) ? '0 : tail + 1'b1;
        end
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> count <= limit);                                    // R2
    AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);                                              // R7
    AST_TAIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !flush && tail == limit - 1'b1) |=> tail == '0);     // R9
    AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !alloc && !flush && count == '0) |=> count == '0);   // R8
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && tail == '0));                        // R10
endmodule

// File: rtl/ualloc_pick.sv
// Two-way grant picker. Alternates when both threads request,
// grants a lone requester at once. Assumes req is already filtered
// for slot availability.
module ualloc_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] gnt
);
    logic favour1;

    // Choose the winner for this cycle.
    always_comb begin
        if (req == 2'b11) gnt = favour1 ? 2'b10 : 2'b01;
        else              gnt = req;
    end

    // Remember who lost: favour thread 1 after thread 0 wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          favour1 <= 1'b0;
        else if (gnt != '0)  favour1 <= gnt[0];
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));                                                // R5
    AST_SOLO_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) == 1) |-> (gnt == req));                      // R5
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11 && gnt[0]) |=> (req != 2'b11 || gnt[1]));        // R4
endmodule

// File: rtl/ualloc_top.sv
// Two-thread capped allocator. Takes the head micro-op of each thread,
// grants reorder slots plus optional load or store slots, enforces a
// per-thread half-pool cap in two-thread mode, returns slots from
// retirement. Assumes the pools are empty when the mode changes.
module ualloc_top
    import ualloc_pkg::*;
#(
    parameter int ROB_DEPTH = 126,
    parameter int LD_DEPTH  = 48,
    parameter int ST_DEPTH  = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_single,
    input  logic                         single_tid,
    input  logic [1:0]                   uop_valid,
    input  logic [1:0]                   uop_ld,
    input  logic [1:0]                   uop_st,
    output logic [1:0]                   uop_take,
    output logic [1:0]                   thr_stall,
    output logic                         gnt_valid,
    output logic                         gnt_tid,
    output logic [$clog2(ROB_DEPTH)-1:0] gnt_rob,
    output logic                         gnt_ld_valid,
    output logic [$clog2(LD_DEPTH)-1:0]  gnt_ld,
    output logic                         gnt_st_valid,
    output logic [$clog2(ST_DEPTH)-1:0]  gnt_st,
    input  logic                         rel_valid,
    input  logic                         rel_tid,
    input  logic [1:0]                   rel_kind
);
    localparam int ROB_IW = $clog2(ROB_DEPTH);
    localparam int LD_IW  = $clog2(LD_DEPTH);
    localparam int ST_IW  = $clog2(ST_DEPTH);

    logic [1:0]        cfg_q;
    logic              flush;
    logic [1:0]        enabled, live, fits, req, gnt;
    logic [1:0]        rob_full, ld_full, st_full;
    logic [ROB_IW-1:0] rob_idx [NTHR];
    logic [LD_IW-1:0]  ld_idx  [NTHR];
    logic [ST_IW-1:0]  st_idx  [NTHR];

    // Remember the configuration; reset loads the current one.
    always_ff @(posedge clk) begin
        cfg_q <= {mode_single, single_tid};
    end

    // Configuration change and per-thread eligibility.
    always_comb begin
        flush = rst_n && (cfg_q != {mode_single, single_tid});
        for (int t = 0; t < NTHR; t++) begin
            enabled[t] = !mode_single || (single_tid == t[0]);
            live[t]    = uop_valid[t] && enabled[t] && !flush;
            fits[t]    = !rob_full[t] && (!uop_ld[t] || !ld_full[t])
                         && (!uop_st[t] || !st_full[t]);
        end
        req       = live & fits;
        thr_stall = live & ~fits;
    end

    ualloc_pick u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    // Per-thread rings for each pool.
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        ualloc_ring #(.DEPTH(ROB_DEPTH), .TID(t)) u_rob (
            .clk(clk), .rst_n(rst_n), .flush(flush), .single(mode_single),
            .alloc(gnt[t]),
            .rel_i(rel_valid && rel_tid == t[0] && rel_kind == RK_ROB),
            .full(rob_full[t]), .idx(rob_idx[t]));
        ualloc_ring #(.DEPTH(LD_DEPTH), .TID(t)) u_ld (
            .clk(clk), .rst_n(rst_n), .flush(flush), .single(mode_single),
            .alloc(gnt[t] && uop_ld[t]),
            .rel_i(rel_valid && rel_tid == t[0] && rel_kind == RK_LD),
            .full(ld_full[t]), .idx(ld_idx[t]));
        ualloc_ring #(.DEPTH(ST_DEPTH), .TID(t)) u_st (
            .clk(clk), .rst_n(rst_n), .flush(flush), .single(mode_single),
            .alloc(gnt[t] && uop_st[t]),
            .rel_i(rel_valid && rel_tid == t[0] && rel_kind == RK_ST),
            .full(st_full[t]), .idx(st_idx[t]));
    end

    // Steer the winning thread's indices to the outputs.
    always_comb begin
        uop_take     = gnt;
        gnt_valid    = |gnt;
        gnt_tid      = gnt[1];
        gnt_rob      = rob_idx[gnt[1]];
        gnt_ld       = ld_idx[gnt[1]];
        gnt_st       = st_idx[gnt[1]];
        gnt_ld_valid = |(gnt & uop_ld);
        gnt_st_valid = |(gnt & uop_st);
    end

    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_stall & uop_take) == 2'b00);                              // R6
    AST_IDLE_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_single |-> (uop_take[!single_tid] == 1'b0
                         && thr_stall[!single_tid] == 1'b0));          // R3
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (uop_take == 2'b00 && thr_stall == 2'b00));          // R10
endmodule

// File: tb/ualloc_top_test.sv
// Bench: small pools, arithmetic model of counts, rings and priority,
// checked every cycle over directed and random stimulus.
module ualloc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD = 8, LDD = 4, STD = 2;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       mode_single = 1'b0, single_tid = 1'b0;
    logic [1:0] uop_valid = '0, uop_ld = '0, uop_st = '0;
    logic [1:0] uop_take, thr_stall;
    logic       gnt_valid, gnt_tid, gnt_ld_valid, gnt_st_valid;
    logic [2:0] gnt_rob;
    logic [1:0] gnt_ld;
    logic [0:0] gnt_st;
    logic       rel_valid = 1'b0, rel_tid = 1'b0;
    logic [1:0] rel_kind = '0;

    int tests = 0, fails = 0;
    bit done = 0;
    int cnt [2][3];
    int tl  [2][3];
    int dep [3] = '{RD, LDD, STD};
    int prio = 0, cq_ms = 0, cq_mt = 0;

    ualloc_top #(.ROB_DEPTH(RD), .LD_DEPTH(LDD), .ST_DEPTH(STD)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic step(input logic [1:0] v, ld, st, input logic rv, rt,
                        input logic [1:0] rk, input logic ms, mt, input string tag);
        int lim[3], g, gt, req, stl, fl;
        @(negedge clk);
        uop_valid = v; uop_ld = ld; uop_st = st;
        rel_valid = rv; rel_tid = rt; rel_kind = rk;
        mode_single = ms; single_tid = mt;
        #1;
        fl = (ms != cq_ms) || (mt != cq_mt);
        for (int k = 0; k < 3; k++) lim[k] = ms ? dep[k] : dep[k] / 2;
        req = 0; stl = 0;
        for (int t = 0; t < 2; t++) begin
            bit en, live, fit;
            en   = !ms || (mt == t);
            live = v[t] && en && !fl;
            fit  = (cnt[t][0] < lim[0]) && (!ld[t] || cnt[t][1] < lim[1])
                   && (!st[t] || cnt[t][2] < lim[2]);
            if (live && fit)  req |= (1 << t);
            if (live && !fit) stl |= (1 << t);
        end
        g = (req == 3) ? (prio ? 2 : 1) : req;
        gt = (g == 2);
        chk(uop_take == g, {tag, " take"}, uop_take, g);
        chk(thr_stall == stl, {tag, "/R6 stall"}, thr_stall, stl);
        chk(gnt_ld_valid == (g != 0 && ld[gt]), "R7 load grant", gnt_ld_valid, g != 0 && ld[gt]);
        chk(gnt_st_valid == (g != 0 && st[gt]), "R7 store grant", gnt_st_valid, g != 0 && st[gt]);
        if (g != 0) begin
            int b;
            b = ms ? 0 : gt * dep[0] / 2;
            chk(gnt_rob == b + tl[gt][0], "R9 rob index", gnt_rob, b + tl[gt][0]);
            if (ld[gt]) begin
                b = ms ? 0 : gt * dep[1] / 2;
                chk(gnt_ld == b + tl[gt][1], "R9 load index", gnt_ld, b + tl[gt][1]);
            end
            if (st[gt]) begin
                b = ms ? 0 : gt * dep[2] / 2;
                chk(gnt_st == b + tl[gt][2], "R9 store index", gnt_st, b + tl[gt][2]);
            end
        end
        @(posedge clk);
        for (int t = 0; t < 2; t++)
            for (int k = 0; k < 3; k++) begin
                bit a, r;
                if (fl) begin
                    cnt[t][k] = 0; tl[t][k] = 0;
                end else begin
                    a = g[t] && (k == 0 || (k == 1 && ld[t]) || (k == 2 && st[t]));
                    r = rv && rt == t && rk == k && cnt[t][k] > 0;
                    cnt[t][k] += int'(a) - int'(r);
                    if (a) tl[t][k] = (tl[t][k] == lim[k] - 1) ? 0 : tl[t][k] + 1;
                end
            end
        if (g != 0) prio = g[0];
        cq_ms = ms; cq_mt = mt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int k = 0; k < 3; k++) begin cnt[t][k] = 0; tl[t][k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle after reset, then first indices per thread
        step(2'b00, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(2'b01, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R2: thread 0 fills its load share, then stalls
        for (int i = 0; i < 4; i++) step(2'b01, 2'b01, 0, 0, 0, 0, 0, 0, "R2");
        // R6/R7: thread 0 blocked on loads, thread 1 keeps going
        for (int i = 0; i < 3; i++) step(2'b11, 2'b01, 0, 0, 0, 0, 0, 0, "R7");
        // R8: release loads of thread 0, empty release ignored
        step(2'b00, 0, 0, 1, 0, 2'd1, 0, 0, "R8");
        step(2'b00, 0, 0, 1, 0, 2'd2, 0, 0, "R8");
        step(2'b00, 0, 0, 1, 1, 2'd3, 0, 0, "R8");
        step(2'b01, 2'b01, 0, 0, 0, 0, 0, 0, "R8");
        // R4: both request, alternating with reorder releases
        for (int i = 0; i < 10; i++)
            step(2'b11, 0, 2'b11, 1, i[0], 2'd0, 0, 0, "R4");
        // R5: lone thread served each cycle
        for (int i = 0; i < 6; i++) step(2'b10, 0, 0, 1, 1, 2'd0, 0, 0, "R5");
        // R10: mode switch flushes, then R3 single mode on thread 1
        step(2'b11, 0, 0, 0, 0, 0, 1, 1, "R10");
        for (int i = 0; i < 12; i++) step(2'b11, 2'b10, 0, 0, 0, 0, 1, 1, "R3");
        step(2'b11, 0, 0, 0, 0, 0, 1, 0, "R10");
        for (int i = 0; i < 10; i++) step(2'b11, 2'b11, 2'b11, 0, 0, 0, 1, 0, "R3");
        step(2'b11, 0, 0, 0, 0, 0, 0, 0, "R10");
        // Random mix of everything
        for (int i = 0; i < 4000; i++) begin
            logic ms, mt;
            ms = cq_ms[0]; mt = cq_mt[0];
            if ($urandom_range(0, 199) == 0) begin ms = $urandom; mt = $urandom; end
            step(2'($urandom), 2'($urandom), 2'($urandom), ($urandom_range(0, 9) < 6),
                 1'($urandom), 2'($urandom), ms, mt, "R5/R4 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule